// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps track of whether the processor runs user code or kernel code. It also owns the two trap registers: the saved return address (EPC) and the trap reason (Cause). When a system call, a synchronous exception or an external interrupt arrives, the block redirects fetch to a single handler address in the same cycle. On the next edge it records where to resume and why, switches to kernel mode and masks interrupts. A return instruction executed in kernel mode redirects fetch to EPC, goes back to user mode and unmasks interrupts.

The mode is a two-state machine, `ST_KERNEL` and `ST_USER`, with two transitions. The *trap entry* transition goes from either state to `ST_KERNEL`. The *return* transition goes from `ST_KERNEL` to `ST_USER`. Interrupts are enabled exactly in `ST_USER`. User code may not touch the trap registers and may not execute the return instruction. Either attempt is flagged and turns into an illegal-instruction trap instead of taking effect.

The pipeline drives one-cycle strobes that are aligned with the program counter of the instruction concerned. It consumes the redirect in the same cycle.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the block is in kernel mode with interrupts disabled, EPC and Cause read as 0, and no redirect is requested.
- R2: `syscall_i` redirects to `HANDLER_PC` in the same cycle; on the next edge the block enters kernel mode, disables interrupts, and sets Cause=1 and EPC=`pc_i`.
- R3: `exc_req_i` traps in either mode; it redirects to `HANDLER_PC`, and on the next edge it sets Cause=`exc_cause_i` (codes 3 page fault, 4 protection fault, 5 divide by zero) and EPC=`pc_i`, with kernel mode and interrupts disabled.
- R4: An interrupt is taken only when `irq_i`, `retire_i` and the interrupt enable are all high in the same cycle; it then traps with Cause=0 and EPC=`pc_i`+`INSTR_BYTES`. `irq_i` without `retire_i` has no effect.
- R5: `eret_i` in kernel mode redirects to the current EPC in the same cycle; on the next edge the block is in user mode with interrupts enabled.
- R6: `eret_i` in user mode raises `illegal_o`, does not return, and instead traps with Cause=2 and EPC=`pc_i`.
- R7: A trap-register access (`csr_req_i`) in user mode raises `illegal_o`, reads 0, writes nothing, and traps with Cause=2 and EPC=`pc_i`.
- R8: In kernel mode, `csr_sel_i`=0 selects EPC and 1 selects Cause; a read returns the value combinationally, and a write (`csr_we_i`) is visible from the next cycle.
- R9: When several trap sources fire together, the priority is `exc_req_i`, then a user-mode illegal access, then `syscall_i`, then the interrupt; only the winner's Cause and EPC are recorded.
- R10: In kernel mode interrupts are not accepted, even with `irq_i` and `retire_i` high.
- R11: A trap entry in the same cycle as a kernel-mode `eret_i` or trap-register write wins: the redirect goes to `HANDLER_PC`, the mode stays kernel, and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| syscall_i | input | 1 | System-call instruction strobe |
| eret_i | input | 1 | Return-from-trap instruction strobe |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | CAUSE_W | Cause code of the exception request |
| irq_i | input | 1 | External interrupt line |
| retire_i | input | 1 | Current instruction completes this cycle |
| pc_i | input | XLEN | Program counter of the current instruction |
| csr_req_i | input | 1 | Trap-register access request |
| csr_we_i | input | 1 | Access is a write |
| csr_sel_i | input | 1 | 0 selects EPC, 1 selects Cause |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data, 0 when not permitted |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | XLEN | Redirect target |
| kernel_mode_o | output | 1 | 1 in kernel mode |
| irq_en_o | output | 1 | Interrupts enabled |
| illegal_o | output | 1 | Forbidden user-mode access or return detected |

## Verification
Trap entry and the return or register-write path can fall in the same cycle. So can several trap sources at once. The bench raises an exception together with a kernel-mode return and an EPC write. It checks that the redirect goes to the handler, that the mode stays kernel, and that a later read of EPC shows the trapping PC and not the written value. It also fires an exception, a syscall and a retiring interrupt together, then a syscall with a retiring interrupt. It judges the winner by reading Cause and EPC back in kernel mode.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } priv_mode_e;

    typedef enum logic {
        ST_KERNEL = 1'b0,
        ST_USER   = 1'b1
    } mode_state_e;

    localparam int unsigned CAUSE_IRQ     = 0;
    localparam int unsigned CAUSE_SYSCALL = 1;
    localparam int unsigned CAUSE_ILLEGAL = 2;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import priv_trap_pkg::*;
#(
    parameter int CAUSE_W = 3
) (
    input  logic               exc_req_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic               illegal_i,
    input  logic               syscall_i,
    input  logic               irq_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               irq_sel_o
);

    always_comb begin
        take_o    = 1'b1;
        cause_o   = '0;
        irq_sel_o = 1'b0;
        unique casez ({exc_req_i, illegal_i, syscall_i, irq_i})
            4'b1???: cause_o = exc_cause_i;
            4'b01??: cause_o = CAUSE_W'(CAUSE_ILLEGAL);
            4'b001?: cause_o = CAUSE_W'(CAUSE_SYSCALL);
            4'b0001: begin
                cause_o   = CAUSE_W'(CAUSE_IRQ);
                irq_sel_o = 1'b1;
            end
            4'b0000: take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trap_we_i,
    input  logic [XLEN-1:0]    trap_epc_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    input  logic               csr_we_i,
    input  logic               csr_sel_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    cause_o
);

    logic [XLEN-1:0] epc_q, cause_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (trap_we_i) begin
            epc_q   <= trap_epc_i;
            cause_q <= XLEN'(trap_cause_i);
        end else if (csr_we_i) begin
            if (csr_sel_i) cause_q <= csr_wdata_i;
            else           epc_q   <= csr_wdata_i;
        end
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;

    // R3: a trap records the offered EPC and cause
    a_r3_trap_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_we_i |=> (epc_q == $past(trap_epc_i)) && (cause_q == XLEN'($past(trap_cause_i))));

    // R8: a permitted write lands in the selected register
    a_r8_csr_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && !trap_we_i) |=>
            (($past(csr_sel_i) ? cause_q : epc_q) == $past(csr_wdata_i)));

endmodule

// File: rtl/priv_mode_fsm.sv
module priv_mode_fsm
    import priv_trap_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       trap_i,
    input  logic       ret_i,
    output priv_mode_e mode_o,
    output logic       irq_en_o
);

    mode_state_e state_q, state_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_KERNEL;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_KERNEL: begin
                if (trap_i)     state_d = ST_KERNEL;
                else if (ret_i) state_d = ST_USER;
            end
            ST_USER: begin
                if (trap_i) state_d = ST_KERNEL;
            end
        endcase
    end

    always_comb begin
        mode_o   = MODE_KERNEL;
        irq_en_o = 1'b0;
        unique case (state_q)
            ST_KERNEL: begin
                mode_o   = MODE_KERNEL;
                irq_en_o = 1'b0;
            end
            ST_USER: begin
                mode_o   = MODE_USER;
                irq_en_o = 1'b1;
            end
        endcase
    end

    // R2: trap entry lands in kernel mode with interrupts masked
    a_r2_trap_enters_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (mode_o == MODE_KERNEL) && !irq_en_o);

    // R5: a return that is not overridden lands in user mode
    a_r5_return_to_user: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_i && !trap_i) |=> (mode_o == MODE_USER) && irq_en_o);

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
    import priv_trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              CAUSE_W     = 3,
    parameter int              INSTR_BYTES = 4,
    parameter logic [XLEN-1:0] HANDLER_PC  = 32'h8000_0180
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               syscall_i,
    input  logic               eret_i,
    input  logic               exc_req_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic               irq_i,
    input  logic               retire_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic               csr_req_i,
    input  logic               csr_we_i,
    input  logic               csr_sel_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic               kernel_mode_o,
    output logic               irq_en_o,
    output logic               illegal_o
);

    localparam logic [XLEN-1:0] PC_STEP = XLEN'(INSTR_BYTES);

    priv_mode_e         mode;
    logic               irq_en;
    logic               in_user;
    logic               illegal;
    logic               irq_take;
    logic               take_trap;
    logic [CAUSE_W-1:0] trap_cause;
    logic               irq_sel;
    logic               take_ret;
    logic               csr_wr;
    logic [XLEN-1:0]    trap_epc;
    logic [XLEN-1:0]    epc_q, cause_q;

    assign in_user  = (mode == MODE_USER);
    assign illegal  = in_user && (eret_i || csr_req_i);
    assign irq_take = irq_i && irq_en && retire_i;

    trap_arbiter #(.CAUSE_W(CAUSE_W)) arb_i (
        .exc_req_i  (exc_req_i),
        .exc_cause_i(exc_cause_i),
        .illegal_i  (illegal),
        .syscall_i  (syscall_i),
        .irq_i      (irq_take),
        .take_o     (take_trap),
        .cause_o    (trap_cause),
        .irq_sel_o  (irq_sel)
    );

    assign take_ret = eret_i && !in_user && !take_trap;
    assign csr_wr   = csr_req_i && csr_we_i && !in_user && !take_trap;
    assign trap_epc = irq_sel ? (pc_i + PC_STEP) : pc_i;

    priv_mode_fsm fsm_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trap_i  (take_trap),
        .ret_i   (take_ret),
        .mode_o  (mode),
        .irq_en_o(irq_en)
    );

    trap_state_regs #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trap_we_i   (take_trap),
        .trap_epc_i  (trap_epc),
        .trap_cause_i(trap_cause),
        .csr_we_i    (csr_wr),
        .csr_sel_i   (csr_sel_i),
        .csr_wdata_i (csr_wdata_i),
        .epc_o       (epc_q),
        .cause_o     (cause_q)
    );

    always_comb begin
        csr_rdata_o = '0;
        if (csr_req_i && !in_user) csr_rdata_o = csr_sel_i ? cause_q : epc_q;
    end

    assign redirect_o    = take_trap || take_ret;
    assign redirect_pc_o = take_trap ? HANDLER_PC : epc_q;
    assign kernel_mode_o = (mode == MODE_KERNEL);
    assign irq_en_o      = irq_en;
    assign illegal_o     = illegal;

    // R2: every trap goes to the single handler address
    a_r2_handler_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_trap |-> redirect_o && (redirect_pc_o == HANDLER_PC));

    // R6: a user-mode return is flagged and becomes a trap
    a_r6_user_eret_traps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kernel_mode_o == 1'b0 && eret_i) |-> illegal_o && redirect_o && (redirect_pc_o == HANDLER_PC));

    // R10: no interrupt is accepted in kernel mode
    a_r10_no_irq_in_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kernel_mode_o |-> !irq_sel);

    // R9: a pipeline exception always supplies the recorded cause
    a_r9_exc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_i |-> take_trap && (trap_cause == exc_cause_i) && !irq_sel);

    // R4: an accepted interrupt needs a retiring instruction
    a_r4_irq_on_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_sel |-> retire_i && irq_i);

endmodule

// File: tb/priv_trap_ctrl_tb_top.sv
module priv_trap_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] HANDLER    = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        syscall, eret, exc_req, irq, retire;
    logic [2:0]  exc_cause;
    logic [31:0] pc;
    logic        csr_req, csr_we, csr_sel;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata, redirect_pc;
    logic        redirect, kmode, irq_en, illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        bit    kernel;
        bit    ie;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_trap_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .syscall_i(syscall), .eret_i(eret),
        .exc_req_i(exc_req), .exc_cause_i(exc_cause), .irq_i(irq), .retire_i(retire),
        .pc_i(pc), .csr_req_i(csr_req), .csr_we_i(csr_we), .csr_sel_i(csr_sel),
        .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .redirect_o(redirect),
        .redirect_pc_o(redirect_pc), .kernel_mode_o(kmode), .irq_en_o(irq_en),
        .illegal_o(illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        syscall = 0; eret = 0; exc_req = 0; exc_cause = 0; irq = 0; retire = 0;
        csr_req = 0; csr_we = 0; csr_sel = 0; csr_wdata = 0;
    endtask

    // driver: check same-cycle outputs, queue the state expected after the edge
    task automatic tick(input string req, input bit er, input logic [31:0] epc,
                        input bit eill, input bit ek, input bit eie);
        exp_t it;
        #1;
        chk(redirect == er, req, 32'(redirect), 32'(er));
        if (er) chk(redirect_pc == epc, req, redirect_pc, epc);
        chk(illegal == eill, req, 32'(illegal), 32'(eill));
        it.req = req; it.kernel = ek; it.ie = eie;
        sb.push_back(it);
        @(negedge clk);
        clr();
    endtask

    task automatic rd(input bit sel, input logic [31:0] exp, input string req);
        csr_req = 1; csr_sel = sel;
        #1;
        chk(csr_rdata == exp, req, csr_rdata, exp);
        tick(req, 0, 0, 0, 1, 0);
    endtask

    task automatic wr_epc(input logic [31:0] val);
        csr_req = 1; csr_we = 1; csr_sel = 0; csr_wdata = val;
        tick("R8", 0, 0, 0, 1, 0);
    endtask

    task automatic ret_to(input logic [31:0] addr);
        eret = 1;
        tick("R5", 1, addr, 0, 0, 1);
    endtask

    // monitor: compares registered mode state against the scoreboard
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            chk(kmode == it.kernel, it.req, 32'(kmode), 32'(it.kernel));
            chk(irq_en == it.ie, it.req, 32'(irq_en), 32'(it.ie));
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clr();
        pc = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk(kmode == 1'b1, "R1", 32'(kmode), 32'd1);
        chk(irq_en == 1'b0, "R1", 32'(irq_en), 32'd0);
        chk(redirect == 1'b0, "R1", 32'(redirect), 32'd0);
        @(negedge clk);
        rd(0, 32'h0, "R1");
        rd(1, 32'h0, "R1");

        // R8: kernel write then read back
        wr_epc(32'h400);
        rd(0, 32'h400, "R8");
        ret_to(32'h400);                      // R5

        // R4: interrupt without retire is ignored
        pc = 32'h404; irq = 1;
        tick("R4", 0, 0, 0, 0, 1);

        // R2: syscall from user
        pc = 32'h408; syscall = 1;
        tick("R2", 1, HANDLER, 0, 1, 0);
        rd(1, 32'd1, "R2");
        rd(0, 32'h408, "R2");

        // R4: interrupt with retire
        wr_epc(32'h500);
        ret_to(32'h500);
        pc = 32'h500; irq = 1; retire = 1;
        tick("R4", 1, HANDLER, 0, 1, 0);
        rd(1, 32'd0, "R4");
        rd(0, 32'h504, "R4");

        // R10: kernel ignores interrupts
        pc = 32'h520; irq = 1; retire = 1;
        tick("R10", 0, 0, 0, 1, 0);
        rd(0, 32'h504, "R10");

        // R6: user-mode eret is illegal
        ret_to(32'h504);
        pc = 32'h504; eret = 1;
        tick("R6", 1, HANDLER, 1, 1, 0);
        rd(1, 32'd2, "R6");
        rd(0, 32'h504, "R6");

        // R7: user-mode register write is blocked and traps
        wr_epc(32'h600);
        ret_to(32'h600);
        pc = 32'h600; csr_req = 1; csr_we = 1; csr_sel = 0; csr_wdata = 32'hDEAD;
        tick("R7", 1, HANDLER, 1, 1, 0);
        rd(0, 32'h600, "R7");
        rd(1, 32'd2, "R7");

        // R9: exception beats syscall and interrupt
        ret_to(32'h600);
        pc = 32'h604; exc_req = 1; exc_cause = 3'd4; syscall = 1; irq = 1; retire = 1;
        tick("R9", 1, HANDLER, 0, 1, 0);
        rd(1, 32'd4, "R9");
        rd(0, 32'h604, "R9");

        // R9: syscall beats interrupt
        wr_epc(32'h700);
        ret_to(32'h700);
        pc = 32'h700; syscall = 1; irq = 1; retire = 1;
        tick("R9", 1, HANDLER, 0, 1, 0);
        rd(1, 32'd1, "R9");
        rd(0, 32'h700, "R9");

        // R11 / R3: exception in kernel overrides eret and register write
        pc = 32'h900; exc_req = 1; exc_cause = 3'd5; eret = 1;
        csr_req = 1; csr_we = 1; csr_sel = 0; csr_wdata = 32'h111;
        tick("R11", 1, HANDLER, 0, 1, 0);
        rd(0, 32'h900, "R11");
        rd(1, 32'd5, "R3");

        // R7: user-mode read returns 0
        wr_epc(32'h800);
        ret_to(32'h800);
        pc = 32'h800; csr_req = 1; csr_sel = 1;
        #1;
        chk(csr_rdata == 32'h0, "R7", csr_rdata, 32'h0);
        tick("R7", 1, HANDLER, 1, 1, 0);

        // R3: page fault in user mode
        ret_to(32'h800);
        pc = 32'h840; exc_req = 1; exc_cause = 3'd3;
        tick("R3", 1, HANDLER, 0, 1, 0);
        rd(1, 32'd3, "R3");
        rd(0, 32'h840, "R3");

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule